// File: doc/BRIEF.md
# Glitch-free two-input clock multiplexer

This block selects one of two unrelated input clocks, `clk_a` or `clk_b`, and drives it onto `clk_out`. The choice is made by `pick_b`, which may change at any time and bears no timing relation to either clock. A switch never cuts a pulse short. The output first lets go of the clock it carries, then holds a fixed idle level. It then takes up the new clock, and only at a moment when doing so cannot start a partial phase.

The parameter `PARK_HIGH` chooses between two builds:
- With `PARK_HIGH = 0`, the idle level is Low. Each side opens and closes its gate on a falling edge of its own clock, so the gate only moves while that clock is low.
- With `PARK_HIGH = 1`, the idle level is High and the same happens on rising edges.

Each input side has its own lane. A lane resynchronises the select into its own clock domain. It also resynchronises a busy flag raised by the other lane. A three-state machine then decides whether its gate may open. The lane states and transitions are:
- **IDLE**: the side is not wanted.
- **WAIT**: the side is wanted, but the other side is still busy.
- **LIVE**: the gate is open.
- **claim** (IDLE to WAIT): taken when the synchronised select asks for this side.
- **withdraw** (WAIT to IDLE) and **release** (LIVE to IDLE): taken when the select no longer asks for this side.
- **grant** (WAIT to LIVE): taken when the synchronised busy flag of the other side is low.

Top module: `glitchfree_clkmux`

## Requirements
- R1: Once a switch has finished, `clk_out` equals `clk_a` while `pick_b` is 0 and equals `clk_b` while `pick_b` is 1.
- R2: With `PARK_HIGH = 0`, the old clock is let go only while it is low. The output then stays Low until the new clock has had a falling edge. After that it follows the new clock, so its first change is a rising edge of the new clock.
- R3: At no time do both inputs pass through to the output together.
- R4: During a switch, the output holds one constant idle level for longer than either input half-period. That level is 0 when `PARK_HIGH = 0` and 1 when `PARK_HIGH = 1`.
- R5: With `PARK_HIGH = 1`, the old clock is let go only while it is high. The output then stays High until the new clock has had a rising edge. After that it follows the new clock, so its first change is a falling edge of the new clock.
- R6: Every High phase and every Low phase of `clk_out` lasts at least as long as the shorter of the two input half-periods, including phases around a switch.
- R7: While `rst_n` is 0, `clk_a` is passed and `clk_b` is blocked. After release with `pick_b` at 0, the output keeps following `clk_a`.
- R8: If `pick_b` changes and returns before a switch is finished, the handshake settles without overlap. The output ends up following the clock that `pick_b` finally selects.
- R9: A switch is complete within `SYNC_STAGES`+2 periods of the old clock plus `SYNC_STAGES`+2 periods of the new clock after `pick_b` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Input clock passed while `pick_b` is 0 |
| clk_b | input | 1 | Input clock passed while `pick_b` is 1 |
| pick_b | input | 1 | Select, asynchronous to both clocks: 0 picks `clk_a`, 1 picks `clk_b` |
| rst_n | input | 1 | Active-low asynchronous reset; forces the `clk_a` side open |
| clk_out | output | 1 | Multiplexed, glitch-free output clock |

## Verification
Two copies of the block are exercised together, one with each idle level. They are fed a 10 ns and a 7.3 ns half-period clock, so clock edges drift against each other and against the select.

Full switches in both directions show three things: whether the idle interval sits at the right level, whether it outlasts any natural phase, and whether the new clock is picked up within the bound.

Select pulses of 25, 60 and 70 ns cover three cases. The shortest may never reach the old lane. The middle one can release the old lane without granting the new one. The longest can let the new lane grant and then release again. These separate a handshake that merely settles from one that settles on the right clock with no short phase.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    // Encoding chosen so gate decode (LIVE) and busy decode (not IDLE)
    // move monotonically on every legal transition.
    typedef enum logic [1:0] {
        LANE_IDLE = 2'b00,
        LANE_WAIT = 2'b01,
        LANE_LIVE = 2'b11
    } lane_state_t;

endpackage

// File: rtl/ckm_sync.sv
module ckm_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ckm_lane.sv
module ckm_lane
    import ckm_pkg::*;
#(
    parameter bit PARK_HIGH   = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter bit START_LIVE  = 1'b0
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic want_raw,
    input  logic peer_busy_raw,
    output logic gate_en,
    output logic busy
);

    localparam lane_state_t RESET_STATE = START_LIVE ? LANE_LIVE : LANE_IDLE;

    // Park-low lanes act on falling edges, park-high lanes on rising edges,
    // so the gate only moves while the clock sits at the idle level.
    logic        lane_clk;
    logic        want_s;
    logic        peer_busy_s;
    lane_state_t state_q;
    lane_state_t state_d;

    assign lane_clk = PARK_HIGH ? clk_in : ~clk_in;

    ckm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(START_LIVE)) u_want_sync (
        .clk   (lane_clk),
        .rst_n (rst_n),
        .d     (want_raw),
        .q     (want_s)
    );

    ckm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(!START_LIVE)) u_peer_sync (
        .clk   (lane_clk),
        .rst_n (rst_n),
        .d     (peer_busy_raw),
        .q     (peer_busy_s)
    );

    always_ff @(posedge lane_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE: if (want_s)            state_d = LANE_WAIT;  // claim
            LANE_WAIT: if (!want_s)           state_d = LANE_IDLE;  // withdraw
                       else if (!peer_busy_s) state_d = LANE_LIVE;  // grant
            LANE_LIVE: if (!want_s)           state_d = LANE_IDLE;  // release
            default:                          state_d = LANE_IDLE;
        endcase
    end

    always_comb begin
        gate_en = (state_q == LANE_LIVE);
        busy    = (state_q != LANE_IDLE);
    end

endmodule

// File: rtl/ckm_gate.sv
module ckm_gate #(
    parameter bit PARK_HIGH = 1'b0
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic en_a,
    input  logic en_b,
    output logic clk_out
);

    generate
        if (PARK_HIGH) begin : g_or_gate
            assign clk_out = (clk_a | ~en_a) & (clk_b | ~en_b);
        end else begin : g_and_gate
            assign clk_out = (clk_a & en_a) | (clk_b & en_b);
        end
    endgenerate

endmodule

// File: rtl/glitchfree_clkmux.sv
module glitchfree_clkmux #(
    parameter bit PARK_HIGH   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic pick_b,
    input  logic rst_n,
    output logic clk_out
);

    localparam int LANES = 2;

    logic [LANES-1:0] lane_clk;
    logic [LANES-1:0] want;
    logic [LANES-1:0] gate;
    logic [LANES-1:0] busy;
    logic             gate_a;
    logic             gate_b;

    assign lane_clk = {clk_b, clk_a};
    assign want     = {pick_b, ~pick_b};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ckm_lane #(
            .PARK_HIGH   (PARK_HIGH),
            .SYNC_STAGES (SYNC_STAGES),
            .START_LIVE  (i == 0)
        ) u_lane (
            .clk_in        (lane_clk[i]),
            .rst_n         (rst_n),
            .want_raw      (want[i]),
            .peer_busy_raw (busy[LANES-1-i]),
            .gate_en       (gate[i]),
            .busy          (busy[i])
        );
    end

    assign gate_a = gate[0];
    assign gate_b = gate[1];

    ckm_gate #(.PARK_HIGH(PARK_HIGH)) u_gate (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .en_a    (gate_a),
        .en_b    (gate_b),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/glitchfree_clkmux_chk.sv
module glitchfree_clkmux_chk #(
    parameter bit PARK_HIGH = 1'b0
) (
    input logic clk_a,
    input logic clk_b,
    input logic rst_n,
    input logic clk_out,
    input logic gate_a,
    input logic gate_b
);

    p_one_gate_on_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(gate_a && gate_b));

    p_one_gate_on_b_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(gate_a && gate_b));

    p_park_level_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!gate_a && !gate_b) |-> (clk_out == PARK_HIGH));

    p_follow_a_r1: assert property (@(posedge clk_b) disable iff (!rst_n)
        gate_a |-> (clk_out == clk_a));

    p_follow_b_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
        gate_b |-> (clk_out == clk_b));

    always @(negedge clk_a) begin
        if (rst_n == 1'b0) begin
            p_reset_side_r7: assert (gate_a && !gate_b);
        end
    end

endmodule

bind glitchfree_clkmux glitchfree_clkmux_chk #(.PARK_HIGH(PARK_HIGH)) u_chk (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .rst_n   (rst_n),
    .clk_out (clk_out),
    .gate_a  (gate_a),
    .gate_b  (gate_b)
);

// File: tb/test_glitchfree_clkmux.sv
`timescale 1ns/1ps
module test_glitchfree_clkmux;

    localparam real HALF_A   = 10.0;   // 50 MHz
    localparam real HALF_B   = 7.3;
    localparam real HALF_MIN = 7.3;
    localparam real HALF_MAX = 10.0;
    localparam real SETTLE   = 4.0 * (2.0 * HALF_A + 2.0 * HALF_B);

    logic clk_a  = 1'b0;
    logic clk_b  = 1'b0;
    logic pick_b = 1'b0;
    logic rst_n  = 1'b1;
    logic out_lo;
    logic out_hi;

    int  checks = 0;
    int  fails  = 0;
    bit  mon_on = 1'b0;
    int  viol_lo = 0;
    int  viol_hi = 0;
    real last_lo = 0.0;
    real last_hi = 0.0;
    real gap_lo  = 0.0;
    real gap_hi  = 0.0;
    bit  lvl_lo  = 1'b0;
    bit  lvl_hi  = 1'b0;

    glitchfree_clkmux #(.PARK_HIGH(1'b0), .SYNC_STAGES(2)) i_glitchfree_clkmux (
        .clk_a (clk_a), .clk_b (clk_b), .pick_b (pick_b), .rst_n (rst_n), .clk_out (out_lo)
    );

    glitchfree_clkmux #(.PARK_HIGH(1'b1), .SYNC_STAGES(2)) i_glitchfree_clkmux_hi (
        .clk_a (clk_a), .clk_b (clk_b), .pick_b (pick_b), .rst_n (rst_n), .clk_out (out_hi)
    );

    initial forever #(HALF_A) clk_a = ~clk_a;
    initial forever #(HALF_B) clk_b = ~clk_b;

    // Phase monitors: every output edge closes a phase.
    always @(out_lo) begin
        real g;
        g = $realtime - last_lo;
        if (mon_on) begin
            if (g < HALF_MIN - 0.001) viol_lo++;
            if (g > gap_lo) begin gap_lo = g; lvl_lo = !out_lo; end
        end
        last_lo = $realtime;
    end

    always @(out_hi) begin
        real g;
        g = $realtime - last_hi;
        if (mon_on) begin
            if (g < HALF_MIN - 0.001) viol_hi++;
            if (g > gap_hi) begin gap_hi = g; lvl_hi = !out_hi; end
        end
        last_hi = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Sample 1 ns after each edge of the expected clock on both copies.
    task automatic check_follow(input bit want_b, input string req);
        int bad_lo = 0;
        int bad_hi = 0;
        for (int k = 0; k < 8; k++) begin
            if (want_b) @(clk_b); else @(clk_a);
            #1;
            if (out_lo !== (want_b ? clk_b : clk_a)) bad_lo++;
            if (out_hi !== (want_b ? clk_b : clk_a)) bad_hi++;
        end
        check(bad_lo == 0, req, "park-low copy mismatching samples", bad_lo, 0);
        check(bad_hi == 0, req, "park-high copy mismatching samples", bad_hi, 0);
    endtask

    task automatic check_phases(input string req);
        check(viol_lo == 0, req, "park-low short phases", viol_lo, 0);
        check(viol_hi == 0, req, "park-high short phases", viol_hi, 0);
    endtask

    task automatic t_reset();
        #1 rst_n = 1'b0;
        #80;
        check_follow(1'b0, "R7 during reset");
        rst_n = 1'b1;
        #50 mon_on = 1'b1;
        check_follow(1'b0, "R7 after release");
    endtask

    task automatic t_switch(input bit to_b);
        gap_lo = 0.0;
        gap_hi = 0.0;
        pick_b = to_b;
        #(SETTLE);
        check_follow(to_b, "R1 R3 R9");
        check(lvl_lo == 1'b0, "R2 R4", "park-low idle level", lvl_lo, 0);
        check(lvl_hi == 1'b1, "R5 R4", "park-high idle level", lvl_hi, 1);
        check(gap_lo > HALF_MAX, "R2 R4", "park-low idle span ps",
              longint'($rtoi(gap_lo * 1000.0)), longint'($rtoi(HALF_MAX * 1000.0)));
        check(gap_hi > HALF_MAX, "R5 R4", "park-high idle span ps",
              longint'($rtoi(gap_hi * 1000.0)), longint'($rtoi(HALF_MAX * 1000.0)));
        check_phases("R6");
    endtask

    task automatic t_toggle_back(input bit final_b, input real hold);
        pick_b = !final_b;
        #(hold);
        pick_b = final_b;
        #(2.0 * SETTLE);
        check_follow(final_b, "R8");
        check_phases("R6 R8");
    endtask

    initial begin
        t_reset();
        t_toggle_back(1'b0, 25.0);
        t_toggle_back(1'b0, 70.0);
        t_switch(1'b1);
        t_toggle_back(1'b1, 25.0);
        t_toggle_back(1'b1, 60.0);
        t_switch(1'b0);
        t_switch(1'b1);
        t_switch(1'b0);
        summary();
        $finish;
    end

    initial begin
        #(200000.0 * 2.0 * HALF_A);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule